// File: doc/BRIEF.md
# Physical memory protection checker

This block decides whether a single memory access may proceed. It takes the access address, the kind of access (load, store or instruction fetch) and the privilege level of the requester. It compares these against a table of up to sixteen protection entries and drives a single allow flag. The flag is combinational, so it is valid in the same cycle as the access inputs. The enclosing pipeline turns a denial into whatever fault it raises.

Each entry has two parts: a permission and mode byte, and a word-granular address register. Software loads both through one synchronous write port. The port addresses either a 32-bit configuration word, which carries four packed entry bytes, or one entry's address register. An entry can match by top-of-range, by a single aligned word, or by a naturally aligned power-of-two region. The lowest-numbered matching entry decides the access. A lock bit freezes an entry until reset. Locked entries are the only ones that also apply to machine-level accesses.

Top module: `pmp_checker`

## Requirements
- R1: After reset every entry is off and unlocked, so user and supervisor accesses are denied and machine accesses are allowed.
- R2: With `cfg_we` high and `cfg_is_addr` low, byte j (bits 8j+7..8j) of `cfg_wdata` is written to the byte of entry 4*`cfg_idx`+j. In that byte, bit 0 is load permission, bit 1 is store permission and bit 2 is fetch permission. Bits 4:3 select the mode: 0 off, 1 top-of-range, 2 single word, 3 power-of-two. Bit 7 is the lock.
- R3: With `cfg_we` and `cfg_is_addr` high, `cfg_wdata` is written to the address register of entry `cfg_idx`. That register holds bits 33:2 of the physical address, so every address bit, including bits 33:32, takes part in matching.
- R4: A top-of-range entry matches when the previous entry's address is less than or equal to the access address, and the access address is below this entry's address. Entry 0 uses zero as its lower bound.
- R5: A single-word entry matches only the four bytes starting at its address.
- R6: A power-of-two entry whose address register has t trailing ones covers 2^(t+3) bytes, aligned to that size. An address register of all ones covers the whole address space.
- R7: `acc_kind` is 0 for a load, 1 for a store and 2 for a fetch. A matched access is allowed only if the bit for its kind is set in the deciding entry.
- R8: When several entries match, the lowest-numbered one decides, even if a higher-numbered entry would grant the access.
- R9: `acc_priv` is 0 for user, 1 for supervisor and 3 for machine. When no entry applies, a user or supervisor access is denied and a machine access is allowed.
- R10: A machine access is checked only against locked entries. Unlocked entries are skipped for it.
- R11: A locked entry ignores later writes to its configuration byte and its address register until reset. Other bytes written in the same configuration word still update their entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_is_addr | input | 1 | 1 selects an address register, 0 selects a configuration word |
| cfg_idx | input | 4 | Entry index (address write) or configuration word index (config write) |
| cfg_wdata | input | 32 | Write data |
| acc_addr | input | 34 | Physical byte address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| acc_allow | output | 1 | 1 when the access is permitted |

## Verification
The table of vectors probes each matching mode just inside and just outside its bounds. For top-of-range, this means the first word, the last word, the exclusive top and the word below the base. For power-of-two, it means the first and last byte of a 256-byte region and of an 8-byte region. These points tell an off-by-one comparison or a wrongly sized mask apart from a correct one.

An overlapping single-word entry is placed in front of a wider top-of-range entry. Store and fetch accesses made there separate a design that honours entry order and permission kind from one that ORs all matches together. The same addresses are repeated at machine level, which distinguishes lock-gated checking from unconditional checking. The directed tests then rewrite a locked entry, its unlocked neighbour and an address above 32 bits, and finally reset the block to show that the lock clears.

// File: rtl/pmp_checker.sv
module pmp_checker #(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_is_addr,
  input  logic [3:0]      cfg_idx,
  input  logic [31:0]     cfg_wdata,
  input  logic [PA_W-1:0] acc_addr,
  input  logic [1:0]      acc_kind,
  input  logic [1:0]      acc_priv,
  output logic            acc_allow
);

  localparam int WORD_W = PA_W - 2;
  localparam int NCFG   = ENTRIES / 4;

  logic [WORD_W-1:0]  acc_word;
  logic               is_m;
  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] perm;
  logic [ENTRIES-1:0] win;
  logic               found;

  assign acc_word = acc_addr[PA_W-1:2];
  assign is_m     = (acc_priv == 2'd3);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [7:0]        cfg_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] care;
    logic              cfg_wr, addr_wr;
    logic              m_tor, m_na4, m_napot, match, ok;

    assign cfg_wr  = cfg_we && !cfg_is_addr && (cfg_idx == 4'(i / 4));
    assign addr_wr = cfg_we &&  cfg_is_addr && (cfg_idx == 4'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q  <= '0;
        addr_q <= '0;
      end else if (!cfg_q[7]) begin
        if (cfg_wr)  cfg_q  <= cfg_wdata[8*(i%4) +: 8] & 8'h9F;
        if (addr_wr) addr_q <= WORD_W'(cfg_wdata);
      end
    end

    if (i == 0) begin : g_base0
      assign base = '0;
    end else begin : g_basen
      assign base = g_ent[i-1].addr_q;
    end

    assign care    = ~(addr_q ^ (addr_q + 1'b1));
    assign m_tor   = (acc_word >= base) && (acc_word < addr_q);
    assign m_na4   = (acc_word == addr_q);
    assign m_napot = (((acc_word ^ addr_q) & care) == '0);

    always_comb begin
      case (cfg_q[4:3])
        2'd1:    match = m_tor;
        2'd2:    match = m_na4;
        2'd3:    match = m_napot;
        default: match = 1'b0;
      endcase
      case (acc_kind)
        2'd0:    ok = cfg_q[0];
        2'd1:    ok = cfg_q[1];
        2'd2:    ok = cfg_q[2];
        default: ok = 1'b0;
      endcase
    end

    assign hit[i]  = match && (!is_m || cfg_q[7]);
    assign perm[i] = ok;

    // R11: a locked entry keeps its contents
    p_lock_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[7] |=> (cfg_q == $past(cfg_q)));
    p_lock_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[7] |=> (addr_q == $past(addr_q)));
    // R10: machine accesses skip unlocked entries
    p_m_skips_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_priv == 2'd3 && !cfg_q[7]) |-> !hit[i]);
  end

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign acc_allow = found ? |(win & perm) : is_m;

  // R8: exactly one deciding entry, and none lower than it matches
  p_single_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win) && ((hit != '0) == (win != '0)));
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> (((win - 1'b1) & hit) == '0));
  // R9: default outcome when nothing applies
  p_default_us_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && acc_priv != 2'd3) |-> !acc_allow);
  p_default_m_allow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && acc_priv == 2'd3) |-> acc_allow);

  initial begin
    if (NCFG * 4 != ENTRIES || ENTRIES > 16 || PA_W != 34)
      $error("pmp_checker: unsupported parameters");
  end

endmodule

// File: tb/test_pmp_checker.sv
module test_pmp_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_is_addr = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [33:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  acc_priv = '0;
  logic        acc_allow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pmp_checker i_pmp_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_addr(cfg_is_addr),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_allow(acc_allow)
  );

  // {addr, kind, priv, expected, requirement number}
  localparam int NV = 20;
  localparam logic [42:0] VEC [NV] = '{
    {34'h0_0000_1000, 2'd0, 2'd0, 1'b1, 4'd5},   // R5 single word, load allowed
    {34'h0_0000_1000, 2'd1, 2'd0, 1'b0, 4'd8},   // R8 entry0 outranks entry1
    {34'h0_0000_1004, 2'd1, 2'd1, 1'b1, 4'd4},   // R4 inside range
    {34'h0_0000_1FFC, 2'd0, 2'd0, 1'b1, 4'd4},   // R4 last word
    {34'h0_0000_2000, 2'd0, 2'd0, 1'b0, 4'd4},   // R4 top exclusive
    {34'h0_0000_0FFC, 2'd0, 2'd0, 1'b0, 4'd4},   // R4 below base
    {34'h0_0000_1004, 2'd2, 2'd0, 1'b0, 4'd7},   // R7 fetch without X
    {34'h0_0000_4000, 2'd2, 2'd0, 1'b1, 4'd6},   // R6 first byte
    {34'h0_0000_40FF, 2'd2, 2'd0, 1'b1, 4'd6},   // R6 last byte of 256
    {34'h0_0000_4100, 2'd2, 2'd0, 1'b0, 4'd6},   // R6 just above
    {34'h0_0000_3FFC, 2'd2, 2'd0, 1'b0, 4'd6},   // R6 just below
    {34'h0_0000_4080, 2'd0, 2'd1, 1'b0, 4'd7},   // R7 load without R
    {34'h0_0000_8004, 2'd0, 2'd0, 1'b1, 4'd6},   // R6 8-byte region
    {34'h0_0000_8008, 2'd0, 2'd0, 1'b0, 4'd6},   // R6 8-byte region end
    {34'h0_0000_8000, 2'd1, 2'd3, 1'b0, 4'd10},  // R10 locked entry binds M
    {34'h0_0000_1000, 2'd1, 2'd3, 1'b1, 4'd10},  // R10 unlocked skipped for M
    {34'h0_0000_9000, 2'd0, 2'd3, 1'b1, 4'd9},   // R9 M default allow
    {34'h0_0000_9000, 2'd0, 2'd1, 1'b0, 4'd9},   // R9 S default deny
    {34'h3_0000_0010, 2'd1, 2'd0, 1'b1, 4'd3},   // R3 upper address bits
    {34'h1_0000_0010, 2'd1, 2'd0, 1'b0, 4'd3}    // R3 upper bits differ
  };

  task automatic wr(input logic is_addr, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_addr = is_addr; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input logic [33:0] a, input logic [1:0] k, input logic [1:0] p,
                     input logic exp, input string req);
    @(negedge clk);
    acc_addr = a; acc_kind = k; acc_priv = p;
    #2;
    checks++;
    if (acc_allow !== exp) begin
      fails++;
      $display("FAIL %s addr=%h kind=%0d priv=%0d actual=%b expected=%b",
               req, a, k, p, acc_allow, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(34'h0_0000_0000, 2'd0, 2'd0, 1'b0, "R1");
    chk(34'h0_0000_1000, 2'd0, 2'd3, 1'b1, "R1");

    // R2, R3: program entries through the write port
    wr(1'b1, 4'd0, 32'h0000_0400);
    wr(1'b1, 4'd1, 32'h0000_0800);
    wr(1'b1, 4'd2, 32'h0000_101F);
    wr(1'b1, 4'd4, 32'h0000_2000);
    wr(1'b1, 4'd5, 32'hC000_0004);
    wr(1'b0, 4'd0, 32'h001C_0B11);
    wr(1'b0, 4'd1, 32'h0000_1399);

    for (int n = 0; n < NV; n++) begin
      chk(VEC[n][42:9], VEC[n][8:7], VEC[n][6:5], VEC[n][4],
          $sformatf("R%0d row%0d", VEC[n][3:0], n));
    end

    // R11: locked entry 4 ignores address and config rewrites
    wr(1'b1, 4'd4, 32'h0000_3000);
    wr(1'b0, 4'd1, 32'h0000_1300);
    chk(34'h0_0000_8004, 2'd0, 2'd0, 1'b1, "R11");
    chk(34'h0_0000_8000, 2'd1, 2'd3, 1'b0, "R11");
    chk(34'h0_0000_C000, 2'd0, 2'd0, 1'b0, "R11");
    // R11: neighbour byte in the same word still updates
    wr(1'b0, 4'd1, 32'h0000_0000);
    chk(34'h3_0000_0010, 2'd0, 2'd0, 1'b0, "R11");
    chk(34'h0_0000_8000, 2'd0, 2'd0, 1'b1, "R11");

    // R1: reset clears the lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(34'h0_0000_8000, 2'd1, 2'd3, 1'b1, "R1");
    chk(34'h0_0000_8000, 2'd0, 2'd0, 1'b0, "R1");

    // R6: all-ones power-of-two covers everything, R2 byte 3 of word 3
    wr(1'b1, 4'd15, 32'hFFFF_FFFF);
    wr(1'b0, 4'd3, 32'h1900_0000);
    chk(34'h0_0000_9000, 2'd0, 2'd0, 1'b1, "R6");
    chk(34'h3_FFFF_FFFC, 2'd0, 2'd1, 1'b1, "R6");
    chk(34'h0_0000_9000, 2'd1, 2'd0, 1'b0, "R7");
    // R2: bits 4:3 = 1 makes entry 0 top-of-range from zero
    wr(1'b1, 4'd0, 32'h0000_0010);
    wr(1'b0, 4'd0, 32'h0000_000A);
    chk(34'h0_0000_0000, 2'd1, 2'd0, 1'b1, "R2");
    chk(34'h0_0000_0000, 2'd0, 2'd0, 1'b0, "R2");
    chk(34'h0_0000_0040, 2'd0, 2'd0, 1'b1, "R4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule